// File: doc/BRIEF.md
# Indirect-Register Host Port with Program Loader

This block sits between a byte-wide host bus and the inside of a chip. Two select lines pick one of four windows: an index register that names an internal register, a data window that reads or writes the named register, a pop window onto a FIFO of sliced data filled from the video side, and a status register whose bits are cleared by writing ones. The host's main use of the port is to load a program into the RAM of an embedded controller. It writes the load index, which holds the controller in reset and sets the load pointer to zero. It then streams bytes through the data window. A dummy write to the release index lets the controller run.

Every data write starts an internal write cycle of a fixed number of clocks. The write-done status bit drops when the cycle starts and rises when it ends. The host can poll that bit, or it can unmask it so the bit drives the interrupt line. Underflow of the FIFO and wrap of the load pointer also set status bits. All status bits go through one enable register before they reach the interrupt.

Top module: `hp_host_port`

## Requirements
- R1: After reset the status register reads 0, `host_irq` is 0, `ctrl_hold` is 1 and the index register reads 0.
- R2: A write with `host_sel`=00 stores `host_wdata` as the index. A read with `host_sel`=00 returns it. Read data appears on `host_rdata` in the clock after the clock edge that sampled `host_rd`, and it holds until the next read.
- R3: A data write (`host_sel`=01) while the index is 0x00..0x07 stores the byte in that general register, and a data read returns it. A data read of an index with no register mapped to it returns 0x00.
- R4: Writing 0x7E as the index sets `ctrl_hold` to 1 and resets the load pointer to location 0.
- R5: While the index is 0x7E, each accepted data byte is stored in program RAM at the load pointer when its write cycle ends, and the pointer then advances by one. The RAM can be read through `pram_raddr`/`pram_rdata`.
- R6: A data write to index 0x7F clears `ctrl_hold`, whatever the byte is. A data read of index 0x7F returns `ctrl_hold` in bit 0.
- R7: Status bit 0 (write done) is 0 after the edge that accepts a data write and becomes 1 exactly WR_LAT clocks later. A data write that arrives while a write cycle is in progress is ignored.
- R8: Writing the status register (`host_sel`=11) clears each bit written as 1 and leaves each bit written as 0 unchanged. The status bits are: bit 0 write done, bit 1 FIFO underflow, bit 2 load-pointer wrap.
- R9: The enable register at index 0xC1 uses the same bit positions as the status register. `host_irq` is 1 exactly when some status bit and its enable bit are both 1.
- R10: A read with `host_sel`=10 pops the sliced-data FIFO and returns bytes in the order they were pushed on `fifo_push`/`fifo_din`.
- R11: A pop read of an empty FIFO returns 0x00 and sets status bit 1.
- R12: When a program byte is stored at location PRAM_DEPTH-1, the pointer wraps to 0 and status bit 2 sets. The next byte is stored at location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Window select: 00 index, 01 data, 10 FIFO pop, 11 status |
| host_wr | input | 1 | Write strobe, one clock per access |
| host_rd | input | 1 | Read strobe, one clock per access |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Registered read byte |
| host_irq | output | 1 | Interrupt, status masked by enables |
| fifo_push | input | 1 | Push strobe from the slicer |
| fifo_din | input | 8 | Sliced byte to push |
| ctrl_hold | output | 1 | Holds the embedded controller in reset |
| pram_raddr | input | 8 | Controller fetch address into program RAM |
| pram_rdata | output | 8 | Program RAM byte at `pram_raddr` |

## Verification
The assertions assume that each host strobe lasts one clock and that `host_wr` and `host_rd` are never high together. They also assume the slicer does not push into a full FIFO. The bench drives every access from tasks that raise a single strobe for exactly one clock. Before the next data write it waits WR_LAT+1 clocks, except in the one directed case that checks that a write arriving during a busy cycle is dropped. It pushes no more bytes than the FIFO holds before it drains them.

// File: rtl/hp_pkg.sv
package hp_pkg;

  localparam int ST_W  = 3;
  localparam int ST_CC = 0;
  localparam int ST_UF = 1;
  localparam int ST_OV = 2;

  typedef enum logic [1:0] {
    SEL_INDEX = 2'b00,
    SEL_DATA  = 2'b01,
    SEL_FIFO  = 2'b10,
    SEL_STAT  = 2'b11
  } sel_e;

  localparam logic [7:0] IDX_LOAD = 8'h7E;
  localparam logic [7:0] IDX_RUN  = 8'h7F;
  localparam logic [7:0] IDX_IEN  = 8'hC1;

  // Sticky status update: events set, clears remove, set wins.
  function automatic logic [ST_W-1:0] sticky_next(
    input logic [ST_W-1:0] cur,
    input logic [ST_W-1:0] set,
    input logic [ST_W-1:0] clr
  );
    return (cur & ~clr) | set;
  endfunction

  function automatic logic masked_any(
    input logic [ST_W-1:0] stat,
    input logic [ST_W-1:0] en
  );
    return |(stat & en);
  endfunction

endpackage

// File: rtl/hp_fifo.sv
module hp_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          full;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem_q[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= bump(wp_q);
      if (do_pop)  rp_q <= bump(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/hp_status.sv
module hp_status
  import hp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_evt,
  input  logic [ST_W-1:0] clr_host,
  input  logic [ST_W-1:0] clr_evt,
  output logic [ST_W-1:0] stat
);
  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= sticky_next(stat, set_evt, clr_host | clr_evt);
  end
endmodule

// File: rtl/hp_load_engine.sv
module hp_load_engine #(
  parameter int DEPTH = 256,
  parameter int LAT   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     start_load,
  input  logic [7:0]               wdata,
  input  logic                     rewind,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic                     busy,
  output logic                     commit,
  output logic                     wrap,
  output logic [$clog2(DEPTH)-1:0] ptr,
  output logic [7:0]               rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(LAT + 1);

  logic [7:0]    mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [7:0]    pend_q;
  logic          pend_load_q;
  logic          store;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign busy   = (cnt_q != '0);
  assign commit = (cnt_q == CW'(1));
  assign store  = commit && pend_load_q;
  assign wrap   = store && (ptr == AW'(DEPTH - 1));
  assign rdata  = mem_q[raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      pend_q      <= '0;
      pend_load_q <= 1'b0;
    end else if (start) begin
      cnt_q       <= CW'(LAT);
      pend_q      <= wdata;
      pend_load_q <= start_load;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (rewind) ptr <= '0;
    else if (store)  ptr <= ptr_next(ptr);
  end

  always_ff @(posedge clk) begin
    if (store) mem_q[ptr] <= pend_q;
  end
endmodule

// File: rtl/hp_host_port.sv
module hp_host_port
  import hp_pkg::*;
#(
  parameter int NUM_GEN    = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int PRAM_DEPTH = 256,
  parameter int WR_LAT     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] host_sel,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       host_irq,
  input  logic       fifo_push,
  input  logic [7:0] fifo_din,
  output logic       ctrl_hold,
  input  logic [7:0] pram_raddr,
  output logic [7:0] pram_rdata
);
  localparam int PAW = $clog2(PRAM_DEPTH);
  localparam int GIW = $clog2(NUM_GEN);

  sel_e            sel;
  logic [7:0]      index_q;
  logic [7:0]      gen_q [NUM_GEN];
  logic [ST_W-1:0] ien_q;
  logic [ST_W-1:0] stat;
  logic [7:0]      rd_mux;
  logic [7:0]      ind_rd;
  logic [7:0]      fifo_dout;
  logic            fifo_empty;

  // Named internal events
  logic            wr_accept;
  logic            idx_wr;
  logic            rewind_evt;
  logic            release_evt;
  logic            pop_rd;
  logic            uf_evt;
  logic            busy;
  logic            commit_evt;
  logic            wrap_evt;
  logic [PAW-1:0]  ptr;

  assign sel         = sel_e'(host_sel);
  assign idx_wr      = host_wr && (sel == SEL_INDEX);
  assign wr_accept   = host_wr && (sel == SEL_DATA) && !busy;
  assign rewind_evt  = idx_wr && (host_wdata == IDX_LOAD);
  assign release_evt = wr_accept && (index_q == IDX_RUN);
  assign pop_rd      = host_rd && (sel == SEL_FIFO);
  assign uf_evt      = pop_rd && fifo_empty;

  always_ff @(posedge clk) begin
    if (!rst_n)      index_q <= '0;
    else if (idx_wr) index_q <= host_wdata;
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    always_ff @(posedge clk) begin
      if (!rst_n)
        gen_q[g] <= '0;
      else if (wr_accept && (index_q == 8'(g)))
        gen_q[g] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ien_q <= '0;
    else if (wr_accept && (index_q == IDX_IEN))
      ien_q <= host_wdata[ST_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           ctrl_hold <= 1'b1;
    else if (rewind_evt)  ctrl_hold <= 1'b1;
    else if (release_evt) ctrl_hold <= 1'b0;
  end

  hp_load_engine #(.DEPTH(PRAM_DEPTH), .LAT(WR_LAT)) u_load (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (wr_accept),
    .start_load (index_q == IDX_LOAD),
    .wdata      (host_wdata),
    .rewind     (rewind_evt),
    .raddr      (pram_raddr[PAW-1:0]),
    .busy       (busy),
    .commit     (commit_evt),
    .wrap       (wrap_evt),
    .ptr        (ptr),
    .rdata      (pram_rdata)
  );

  hp_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .din   (fifo_din),
    .pop   (pop_rd),
    .dout  (fifo_dout),
    .empty (fifo_empty)
  );

  logic [ST_W-1:0] set_vec, clr_host_vec, clr_evt_vec;
  always_comb begin
    set_vec        = '0;
    set_vec[ST_CC] = commit_evt;
    set_vec[ST_UF] = uf_evt;
    set_vec[ST_OV] = wrap_evt;
    clr_evt_vec        = '0;
    clr_evt_vec[ST_CC] = wr_accept;
    clr_host_vec = (host_wr && (sel == SEL_STAT)) ? host_wdata[ST_W-1:0] : '0;
  end

  hp_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (set_vec),
    .clr_host (clr_host_vec),
    .clr_evt  (clr_evt_vec),
    .stat     (stat)
  );

  assign host_irq = masked_any(stat, ien_q);

  always_comb begin
    if (index_q < 8'(NUM_GEN))     ind_rd = gen_q[index_q[GIW-1:0]];
    else if (index_q == IDX_IEN)   ind_rd = {{(8-ST_W){1'b0}}, ien_q};
    else if (index_q == IDX_RUN)   ind_rd = {7'b0, ctrl_hold};
    else                           ind_rd = 8'h00;
  end

  always_comb begin
    case (sel)
      SEL_INDEX: rd_mux = index_q;
      SEL_DATA:  rd_mux = ind_rd;
      SEL_FIFO:  rd_mux = fifo_empty ? 8'h00 : fifo_dout;
      default:   rd_mux = {{(8-ST_W){1'b0}}, stat};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end
endmodule

// File: rtl/hp_host_port_chk.sv
module hp_host_port_chk
  import hp_pkg::*;
#(
  parameter int PRAM_DEPTH = 256
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_accept,
  input logic                          commit_evt,
  input logic                          wrap_evt,
  input logic                          uf_evt,
  input logic                          rewind_evt,
  input logic                          release_evt,
  input logic [ST_W-1:0]               stat,
  input logic [$clog2(PRAM_DEPTH)-1:0] ptr,
  input logic                          ctrl_hold
);
  // R7
  wd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !stat[ST_CC]);
  // R7
  wd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> stat[ST_CC]);
  // R4
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_evt |=> (ptr == '0) && ctrl_hold);
  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (release_evt && !rewind_evt) |=> !ctrl_hold);
  // R11
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> stat[ST_UF]);
  // R12
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> stat[ST_OV] && (ptr == '0));
endmodule

bind hp_host_port hp_host_port_chk #(.PRAM_DEPTH(PRAM_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_accept   (wr_accept),
  .commit_evt  (commit_evt),
  .wrap_evt    (wrap_evt),
  .uf_evt      (uf_evt),
  .rewind_evt  (rewind_evt),
  .release_evt (release_evt),
  .stat        (stat),
  .ptr         (ptr),
  .ctrl_hold   (ctrl_hold)
);

// File: tb/sim_hp_host_port.sv
module sim_hp_host_port;
  localparam int LAT   = 4;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_sel = 2'b00;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       host_irq;
  logic       fifo_push = 1'b0;
  logic [7:0] fifo_din = 8'h00;
  logic       ctrl_hold;
  logic [7:0] pram_raddr = 8'h00;
  logic [7:0] pram_rdata;

  int tests = 0;
  int fails = 0;
  logic [7:0] gen_m [8];
  logic [7:0] prog_m [DEPTH];

  always #5 clk = ~clk;

  hp_host_port #(.PRAM_DEPTH(DEPTH), .WR_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_irq(host_irq), .fifo_push(fifo_push), .fifo_din(fifo_din),
    .ctrl_hold(ctrl_hold), .pram_raddr(pram_raddr), .pram_rdata(pram_rdata)
  );

  function automatic logic [7:0] prog_byte(input int i);
    return 8'((i * 37 + 11) ^ 8'h5A);
  endfunction

  function automatic logic irq_model(input logic [2:0] st, input logic [2:0] en);
    for (int b = 0; b < 3; b++) if (st[b] && en[b]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    host_sel = s; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wr_data_wait(input logic [7:0] d);
    wr(2'b01, d);
    repeat (LAT + 1) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk);
    host_sel = s; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] st;
    int idx;
    void'($urandom(32'h1234));
    for (int i = 0; i < 8; i++) gen_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", host_irq, 0);
    chk("R1 hold", ctrl_hold, 1);
    rd(2'b11, v); chk("R1 status", v, 0);
    rd(2'b00, v); chk("R1 index", v, 0);

    // R2 index readback, rdata holds
    wr(2'b00, 8'hA5); rd(2'b00, v); chk("R2 index", v, 8'hA5);
    @(negedge clk); chk("R2 hold", host_rdata, 8'hA5);

    // R3 random general register traffic against a model
    for (int n = 0; n < 40; n++) begin
      idx = int'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 1) begin
        gen_m[idx] = 8'($urandom);
        wr(2'b00, 8'(idx)); wr_data_wait(gen_m[idx]);
      end else begin
        wr(2'b00, 8'(idx)); rd(2'b01, v);
        chk("R3 gen reg", v, gen_m[idx]);
      end
    end
    wr(2'b00, 8'h40); rd(2'b01, v); chk("R3 unmapped", v, 0);

    // R9 enable write-done, irq follows status
    wr(2'b00, 8'hC1); wr_data_wait(8'h01);
    rd(2'b01, v); chk("R9 enable readback", v, 8'h01);
    chk("R9 irq on", host_irq, 1);

    // R7 exact write-done timing observed at host_irq
    wr(2'b00, 8'h02);
    wr(2'b01, 8'h77);
    for (int k = 0; k <= LAT; k++) begin
      chk("R7 done timing", host_irq, (k == LAT) ? 1 : 0);
      if (k < LAT) @(negedge clk);
    end
    gen_m[2] = 8'h77;

    // R7 write during busy cycle dropped
    wr(2'b01, 8'h11);
    wr(2'b01, 8'h22);
    repeat (LAT + 1) @(negedge clk);
    rd(2'b01, v); chk("R7 busy drop", v, 8'h11);

    // R10 FIFO order
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); fifo_push = 1'b1; fifo_din = 8'(8'hC0 + i);
    end
    @(negedge clk); fifo_push = 1'b0;
    for (int i = 0; i < 5; i++) begin
      rd(2'b10, v); chk("R10 fifo order", v, 8'hC0 + i);
    end

    // R11 empty pop
    rd(2'b10, v); chk("R11 empty data", v, 0);
    rd(2'b11, st); chk("R11 underflow bit", int'(st[1]), 1);

    // R8 W1C: clear UF only, write-done stays
    wr(2'b11, 8'h02); rd(2'b11, st); chk("R8 w1c", st, 8'h01);
    wr(2'b11, 8'h00); rd(2'b11, st); chk("R8 zero keeps", st, 8'h01);
    // R9 mask: clear write-done, enable only UF, then cause UF
    wr(2'b11, 8'h01);
    chk("R9 irq off", host_irq, irq_model(3'b000, 3'b001));
    wr(2'b00, 8'hC1); wr_data_wait(8'h02);
    chk("R9 masked done", host_irq, irq_model(3'b001, 3'b010));
    rd(2'b10, v);
    @(negedge clk);
    chk("R9 uf irq", host_irq, irq_model(3'b011, 3'b010));
    wr(2'b11, 8'h07);

    // R4 load index, controller held
    wr(2'b00, 8'h7F); wr_data_wait(8'h3C);
    chk("R6 release", ctrl_hold, 0);
    rd(2'b01, v); chk("R6 read run", v, 0);
    wr(2'b00, 8'h7E);
    chk("R4 hold", ctrl_hold, 1);

    // R5 / R12 full program load with wrap
    for (int i = 0; i < DEPTH; i++) begin
      prog_m[i] = prog_byte(i);
      wr_data_wait(prog_m[i]);
      if (i == 2) begin
        pram_raddr = 8'd2; #1;
        chk("R5 stored", pram_rdata, prog_m[2]);
      end
    end
    rd(2'b11, st); chk("R12 wrap bit", int'(st[2]), 1);
    for (int i = 0; i < DEPTH; i += 17) begin
      pram_raddr = 8'(i); #1;
      chk("R5 program", pram_rdata, prog_m[i]);
    end
    wr_data_wait(8'hEE);
    pram_raddr = 8'd0; #1; chk("R12 wrap dest", pram_rdata, 8'hEE);

    // R4 rewind mid-load
    wr_data_wait(8'h91);
    wr(2'b00, 8'h7E); wr_data_wait(8'h42);
    pram_raddr = 8'd0; #1; chk("R4 rewind", pram_rdata, 8'h42);
    pram_raddr = 8'd1; #1; chk("R4 untouched", pram_rdata, 8'h91);

    // R6 release with arbitrary byte
    wr(2'b00, 8'h7F); wr_data_wait(8'($urandom));
    chk("R6 release any", ctrl_hold, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule